// File: doc/BRIEF.md
# DAC Sample Holding and Trigger Transfer Front End

This block is the digital front end of a single-channel 12-bit digital-to-analog converter. Software places a sample through one of three write addresses, each taking a different slice of the 16-bit write bus. The chosen slice is normalised into a 12-bit internal holding register, which software cannot address directly.

The held sample reaches the 12-bit converter code output in one of three ways. With triggering off, the transfer follows every sample write on its own. With triggering on, the transfer waits for a one-shot software trigger bit or for a rising edge on the selected hardware trigger input. Five hardware trigger inputs are provided: a general timer trigger, three low-power timer outputs and an external interrupt line. The analog enable bit only reaches the converter. The register path keeps accepting samples and moving them to the output while that bit is clear.

Top module: `dac_hold_xfer`

## Requirements
- R1: A write to address 2 takes wrData[7:0] into holding bits [11:4] and clears holding bits [3:0]. wrData[15:8] has no effect.
- R2: A write to address 3 takes wrData[15:4] into holding bits [11:0]. wrData[3:0] has no effect.
- R3: A write to address 4 takes wrData[11:0] into holding bits [11:0]. wrData[15:12] has no effect.
- R4: With trigger mode off (control bit 1 = 0), dacCode is unchanged in the cycle of a sample write. It equals the new holding value from the following clock edge onward.
- R5: With trigger mode on, a sample write changes only the holding register. dacCode keeps its value until a trigger arrives.
- R6: Writing 1 to bit 0 of address 1 while trigger mode is on sets swTrigPend. On the next edge, dacCode takes the holding value and swTrigPend clears by itself. This works whatever source is selected. While trigger mode is off, the write is ignored and swTrigPend stays 0.
- R7: In trigger mode, a 0-to-1 change on hwTrig[trigSel], where the select is control bits [4:2], loads dacCode two edges after the input rises. A level held high causes no further loads. Inputs that are not selected are ignored.
- R8: Select codes 5, 6 and 7 choose no hardware source. While one of them is selected, no hardware trigger transfer occurs.
- R9: anaEnable follows control bit 0 from the edge of the control write (address 0). Sample writes and transfers work identically while it is 0.
- R10: An active-low reset clears the holding register, dacCode, anaEnable, swTrigPend and all control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address: 0 control, 1 software trigger, 2/3/4 sample ports |
| wrData | input | 16 | Write data |
| hwTrig | input | 5 | Hardware trigger inputs, one per source |
| dacCode | output | 12 | Code driving the converter |
| anaEnable | output | 1 | Analog channel enable |
| swTrigPend | output | 1 | Software trigger request still pending |

## Verification
The bench builds the block with its default parameters: a 12-bit code, a 16-bit write bus, five trigger sources and a 3-bit select. With these values every select code can be reached, including the three codes that select no source, and every slice boundary of the three sample ports can be reached. Write data with all the unused bits set to one exposes any leakage of the ignored bits into the holding register. A hardware input held high across a sample write shows that only edges cause a load.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_SWTRIG = 3'd1;
  localparam logic [ADDR_W-1:0] A_R8 = 3'd2;
  localparam logic [ADDR_W-1:0] A_L12 = 3'd3;
  localparam logic [ADDR_W-1:0] A_R12 = 3'd4;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_R8   = 2'd1,
    LD_L12  = 2'd2,
    LD_R12  = 2'd3
  } loadKind_e;

  typedef struct packed {
    loadKind_e load;
    logic      xfer;
  } strobe_t;
endpackage

// File: rtl/dacfe_datapath.sv
module dacfe_datapath
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BUS_W-1:0]  wrData,
  output logic [DATA_W-1:0] dacCode
);
  localparam int NARROW_W = DATA_W - 4;
  localparam int PAD_W    = DATA_W - NARROW_W;

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shaped;

  always_comb begin
    unique case (stb.load)
      LD_R8:   shaped = {wrData[NARROW_W-1:0], {PAD_W{1'b0}}};
      LD_L12:  shaped = wrData[BUS_W-1 -: DATA_W];
      LD_R12:  shaped = wrData[DATA_W-1:0];
      default: shaped = holdReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      dacCode <= '0;
    end else begin
      if (stb.load != LD_NONE) holdReg <= shaped;
      if (stb.xfer) dacCode <= holdReg;
    end
  end
endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int NUM_TRIG = 5,
  parameter int SEL_W    = 3,
  parameter int BUS_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [NUM_TRIG-1:0] hwTrig,
  output strobe_t             stb,
  output logic                anaEnable,
  output logic                swTrigPend
);
  localparam int SEL_LSB = 2;

  logic             chanEn;
  logic             trigEn;
  logic [SEL_W-1:0] trigSel;
  logic             selPrev;
  logic             hwReq;
  logic             autoPend;
  logic             swTrig;
  logic [NUM_TRIG-1:0] selHit;
  logic             selLevel;
  logic             dataWrite;
  loadKind_e        loadKind;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_sel
    assign selHit[g] = hwTrig[g] && (trigSel == SEL_W'(g));
  end
  assign selLevel = |selHit;

  always_comb begin
    loadKind = LD_NONE;
    if (wrEn) begin
      unique case (wrAddr)
        A_R8:    loadKind = LD_R8;
        A_L12:   loadKind = LD_L12;
        A_R12:   loadKind = LD_R12;
        default: loadKind = LD_NONE;
      endcase
    end
  end
  assign dataWrite = (loadKind != LD_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanEn   <= 1'b0;
      trigEn   <= 1'b0;
      trigSel  <= '0;
      selPrev  <= 1'b0;
      hwReq    <= 1'b0;
      autoPend <= 1'b0;
      swTrig   <= 1'b0;
    end else begin
      if (wrEn && wrAddr == A_CTRL) begin
        chanEn  <= wrData[0];
        trigEn  <= wrData[1];
        trigSel <= wrData[SEL_LSB +: SEL_W];
      end
      selPrev  <= selLevel;
      hwReq    <= trigEn && selLevel && !selPrev;
      autoPend <= dataWrite && !trigEn;
      swTrig   <= trigEn && wrEn && (wrAddr == A_SWTRIG) && wrData[0];
    end
  end

  assign stb.load   = loadKind;
  assign stb.xfer   = autoPend || swTrig || hwReq;
  assign anaEnable  = chanEn;
  assign swTrigPend = swTrig;
endmodule

// File: rtl/dac_hold_xfer.sv
module dac_hold_xfer
  import dacfe_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int BUS_W    = 16,
  parameter int NUM_TRIG = 5,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [NUM_TRIG-1:0] hwTrig,
  output logic [DATA_W-1:0]   dacCode,
  output logic                anaEnable,
  output logic                swTrigPend
);
  strobe_t stb;

  dacfe_ctrl #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W), .BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hwTrig(hwTrig), .stb(stb), .anaEnable(anaEnable), .swTrigPend(swTrigPend)
  );

  dacfe_datapath #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .dacCode(dacCode)
  );
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk
  import dacfe_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int BUS_W    = 16,
  parameter int NUM_TRIG = 5,
  parameter int SEL_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [2:0]          wrAddr,
  input logic [BUS_W-1:0]    wrData,
  input logic [NUM_TRIG-1:0] hwTrig,
  input logic [DATA_W-1:0]   dacCode,
  input logic                anaEnable,
  input logic                swTrigPend
);
  logic             modeTrig;
  logic [SEL_W-1:0] selCode;
  logic             unusedHw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeTrig <= 1'b0;
      selCode  <= '0;
    end else if (wrEn && wrAddr == A_CTRL) begin
      modeTrig <= wrData[1];
      selCode  <= wrData[2 +: SEL_W];
    end
  end
  assign unusedHw = |hwTrig;

  // R10
  always @(posedge clk) begin
    if (!rstN) begin
      reset_clear_chk: assert (dacCode == '0 && !anaEnable && !swTrigPend);
    end
  end

  // R6
  swtrig_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    swTrigPend && !(wrEn && wrAddr == A_SWTRIG) |=> !swTrigPend);

  // R8
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeTrig, 2) && $past(selCode, 2) >= SEL_W'(NUM_TRIG) && $past(modeTrig)
     && !$past(swTrigPend) && (unusedHw || !unusedHw)) |-> $stable(dacCode));

  // R9
  ana_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_CTRL) |=> anaEnable == $past(wrData[0]));

  // R1
  narrow_auto_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_R8 && !modeTrig) |=> ##1
      dacCode == {$past(wrData[DATA_W-5:0], 2), 4'b0000});

  // R3
  right_auto_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_R12 && !modeTrig) |=> ##1
      dacCode == $past(wrData[DATA_W-1:0], 2));
endmodule

bind dac_hold_xfer dacfe_chk #(
  .DATA_W(DATA_W), .BUS_W(BUS_W), .NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/tb_dac_hold_xfer.sv
module tb_dac_hold_xfer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [4:0]  hwTrig = '0;
  logic [11:0] dacCode;
  logic        anaEnable;
  logic        swTrigPend;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    int          kind;
    logic [11:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  dac_hold_xfer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hwTrig(hwTrig), .dacCode(dacCode), .anaEnable(anaEnable), .swTrigPend(swTrigPend)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int due, input int kind, input logic [11:0] val, input string tag);
    exp_t e;
    e.due = due; e.kind = kind; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; wrAddr = 3'd7;
  endtask

  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      logic [11:0] act;
      e = sb.pop_front();
      act = (e.kind == 0) ? dacCode : (e.kind == 1) ? {11'd0, swTrigPend} : {11'd0, anaEnable};
      checks++;
      if (e.due != cyc || act !== e.val) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h (due %0d at %0d)", e.tag, act, e.val, e.due, cyc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    push(cyc, 0, 12'h000, "R10 code after reset");
    push(cyc, 1, 12'h000, "R10 pend after reset");
    push(cyc, 2, 12'h000, "R10 enable after reset");
    step(1);

    wr(3'd0, 16'h0000);
    wr(3'd2, 16'hFFA5);
    push(cyc, 0, 12'h000, "R4 unchanged in write cycle");
    push(cyc + 1, 0, 12'hA50, "R1 narrow port, R9 digital path with enable off");
    step(1);
    wr(3'd3, 16'hABCF);
    push(cyc + 1, 0, 12'hABC, "R2 left port");
    step(1);
    wr(3'd4, 16'hF123);
    push(cyc + 1, 0, 12'h123, "R3 right port");
    step(1);

    wr(3'd0, 16'h0001);
    push(cyc, 2, 12'h001, "R9 enable set");
    wr(3'd0, 16'h0003);
    wr(3'd4, 16'h0456);
    push(cyc + 1, 0, 12'h123, "R5 no auto transfer");
    push(cyc + 3, 0, 12'h123, "R5 still held");
    step(3);
    wr(3'd1, 16'h0001);
    push(cyc, 1, 12'h001, "R6 pend set");
    push(cyc + 1, 1, 12'h000, "R6 pend self clears");
    push(cyc + 1, 0, 12'h456, "R6 software transfer");
    step(2);

    wr(3'd0, 16'h000B);
    wr(3'd4, 16'h0789);
    hwTrig = 5'b00001;
    step(3);
    push(cyc, 0, 12'h456, "R7 unselected input ignored");
    hwTrig = 5'b00000;
    step(2);
    hwTrig = 5'b00100;
    push(cyc + 1, 0, 12'h456, "R7 not yet loaded");
    push(cyc + 2, 0, 12'h789, "R7 rising edge loads");
    step(3);
    wr(3'd4, 16'h0111);
    step(3);
    push(cyc, 0, 12'h789, "R7 held level no reload");
    hwTrig = 5'b00000;
    step(1);
    hwTrig = 5'b00100;
    push(cyc + 2, 0, 12'h111, "R7 second edge loads");
    step(3);
    hwTrig = 5'b00000;

    wr(3'd0, 16'h001B);
    wr(3'd4, 16'h0222);
    step(1);
    hwTrig = 5'b11111;
    step(3);
    push(cyc, 0, 12'h111, "R8 unused select no transfer");
    hwTrig = 5'b00000;
    step(1);
    wr(3'd1, 16'h0001);
    push(cyc + 1, 0, 12'h222, "R6 software trigger under unused select");
    step(2);

    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h0001);
    push(cyc, 1, 12'h000, "R6 ignored with trigger mode off");
    push(cyc + 1, 0, 12'h222, "R6 ignored write leaves code");
    step(2);

    rstN = 1'b0;
    step(1);
    push(cyc, 0, 12'h000, "R10 code cleared");
    push(cyc, 2, 12'h000, "R10 enable cleared");
    step(1);
    rstN = 1'b1;
    step(2);
    wr(3'd4, 16'h0345);
    push(cyc + 1, 0, 12'h345, "R10 control cleared so auto mode");
    step(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule